// File: doc/BRIEF.md
# Write-Protection Command Sequence Decoder

This block sits on the path of captured write cycles heading into a byte-wide flash-style memory. Each cycle carries an address and a data byte. The block watches these cycles for multi-cycle unlock sequences, and from them it drives a small set of outcomes:

- a software write-protection flag;
- a page-load window;
- a chip-erase start pulse;
- a product-identifier read mode.

Ordinary writes go forward to a separate write engine only when the protection state allows them. The forwarded writes leave on a registered data-write channel. Page-load starts and erase starts leave as single-cycle pulses.

The protection flag behaves like a non-volatile bit. It powers up set, and the reset input does not touch it. While identifier mode is active, reads of addresses 0 and 1 return fixed identifier bytes instead of array data.

Top module: `wp_cmd_decoder`

## Requirements
- R1: After reset, `dataWrValid`, `loadStart`, `eraseStart` and `idMode` are 0. `protOn` powers up as 1.
- R2: Three writes arm protection and open a page-load window. They are AAh to 5555h, then 55h to 2AAAh, then A0h to 5555h. One cycle after the third write, `protOn` is 1 and `loadStart` pulses for one cycle. Command writes are never forwarded.
- R3: While `protOn` is 1 and no window is open, a write that is not part of a command is dropped. In that case `dataWrValid` and `loadStart` stay 0.
- R4: A write that arrives within LOAD_WINDOW cycles of the previous accepted write falls inside the open window. It is forwarded on `dataWrAddr`/`dataWrData` with `dataWrValid` high one cycle later. A later write finds the window closed.
- R5: Six writes clear `protOn` one cycle after the last write. They are AAh to 5555h, 55h to 2AAAh, 80h to 5555h, AAh to 5555h, 55h to 2AAAh, and DISABLE_CODE (default 20h) to 5555h.
- R6: While `protOn` is 0, an ordinary write with no window open is forwarded and opens a window, with `loadStart` pulsing once. Further writes inside that window are forwarded without another `loadStart`.
- R7: The reset input does not change `protOn`, whether it is 0 or 1.
- R8: Command addresses are compared on address bits 14..0 only. For example, AAh written to 15555h counts as the first step.
- R9: A chip erase starts from the six-write form with ERASE_CODE (default 10h) as the sixth byte. `eraseStart` then pulses for exactly one cycle.
- R10: Identifier mode is entered by the six-write form with ID_ENTER_CODE (default 60h) as the sixth byte. In that mode a read of address 0 returns DAh, a read of address 1 returns C1h, and other addresses return `arrayRdData`. The three-write form with ID_EXIT_CODE (default F0h) as the third byte leaves the mode.
- R11: A write that does not match the next expected step abandons the partial sequence and is handled as an ordinary write. Later steps must then begin again from AAh at 5555h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset (protection flag excluded) |
| wrValid | input | 1 | A captured write cycle is present |
| wrAddr | input | ADDR_W | Address of the captured write |
| wrData | input | 8 | Data of the captured write |
| rdAddr | input | ADDR_W | Read address |
| arrayRdData | input | 8 | Byte read from the storage array |
| rdData | output | 8 | Read data, with identifier override applied |
| dataWrValid | output | 1 | Forwarded write to the write engine |
| dataWrAddr | output | ADDR_W | Address of the forwarded write |
| dataWrData | output | 8 | Data of the forwarded write |
| loadStart | output | 1 | One-cycle pulse when a page-load window opens |
| eraseStart | output | 1 | One-cycle pulse to start chip erase |
| protOn | output | 1 | Software write protection is active |
| idMode | output | 1 | Identifier read mode is active |

## Verification
The bench builds the block with LOAD_WINDOW set to 6 and keeps all command codes at their defaults. This makes window expiry reachable within a few idle cycles, so the bench can place writes exactly on the last in-window cycle and on the first cycle after it.

The default codes let one stimulus table cover the whole command set: arming, disarming, erase, identifier entry and exit, and abandoned sequences. Directed steps then check the identifier read override. They also check that the protection flag survives reset in both of its states.

// File: rtl/wpdec_pkg.sv
package wpdec_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_C1,
    SEQ_C2,
    SEQ_C3,
    SEQ_C4,
    SEQ_C5
  } seqState_t;

  typedef struct packed {
    logic              unlockA;
    logic              unlockB;
    logic              atCmdAddr;
    logic [BYTE_W-1:0] code;
  } cmdHit_t;

  typedef struct packed {
    logic passWrite;
    logic openLoad;
    logic startErase;
    logic idMode;
  } ctrlStrobe_t;
endpackage

// File: rtl/wpdec_datapath.sv
module wpdec_datapath
  import wpdec_pkg::*;
#(
  parameter int             ADDR_W      = 17,
  parameter int             CMD_BITS    = 15,
  parameter logic [14:0]    ADDR_A      = 15'h5555,
  parameter logic [14:0]    ADDR_B      = 15'h2AAA,
  parameter logic [7:0]     UNLOCK_A    = 8'hAA,
  parameter logic [7:0]     UNLOCK_B    = 8'h55,
  parameter logic [7:0]     ID_MAKER    = 8'hDA,
  parameter logic [7:0]     ID_DEVICE   = 8'hC1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [BYTE_W-1:0] arrayRdData,
  input  ctrlStrobe_t       strobe,
  output cmdHit_t           hit,
  output logic [BYTE_W-1:0] rdData,
  output logic              dataWrValid,
  output logic [ADDR_W-1:0] dataWrAddr,
  output logic [BYTE_W-1:0] dataWrData,
  output logic              loadStart,
  output logic              eraseStart
);
  localparam int ID_COUNT = 2;
  localparam logic [BYTE_W-1:0] ID_BYTES [ID_COUNT] = '{ID_MAKER, ID_DEVICE};

  logic [CMD_BITS-1:0] cmdAddr;
  logic                idWindow;

  assign cmdAddr = wrAddr[CMD_BITS-1:0];

  always_comb begin
    hit.atCmdAddr = (cmdAddr == CMD_BITS'(ADDR_A));
    hit.unlockA   = hit.atCmdAddr && (wrData == UNLOCK_A);
    hit.unlockB   = (cmdAddr == CMD_BITS'(ADDR_B)) && (wrData == UNLOCK_B);
    hit.code      = wrData;
  end

  // Identifier override covers the two lowest addresses only
  assign idWindow = strobe.idMode && (rdAddr[ADDR_W-1:1] == '0);

  always_comb begin
    if (idWindow) rdData = ID_BYTES[rdAddr[0]];
    else          rdData = arrayRdData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataWrValid <= 1'b0;
      dataWrAddr  <= '0;
      dataWrData  <= '0;
      loadStart   <= 1'b0;
      eraseStart  <= 1'b0;
    end else begin
      dataWrValid <= strobe.passWrite;
      loadStart   <= strobe.openLoad;
      eraseStart  <= strobe.startErase;
      if (strobe.passWrite) begin
        dataWrAddr <= wrAddr;
        dataWrData <= wrData;
      end
    end
  end

  AST_FWD_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    dataWrValid |-> $past(wrValid)); // R4
  AST_ERASE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |=> !eraseStart); // R9
  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    loadStart |=> !loadStart); // R6
endmodule

// File: rtl/wpdec_seq_ctrl.sv
module wpdec_seq_ctrl
  import wpdec_pkg::*;
#(
  parameter int         LOAD_WINDOW   = 6000,
  parameter logic [7:0] ENABLE_CODE   = 8'hA0,
  parameter logic [7:0] SIX_PREFIX    = 8'h80,
  parameter logic [7:0] DISABLE_CODE  = 8'h20,
  parameter logic [7:0] ERASE_CODE    = 8'h10,
  parameter logic [7:0] ID_ENTER_CODE = 8'h60,
  parameter logic [7:0] ID_EXIT_CODE  = 8'hF0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrValid,
  input  cmdHit_t     hit,
  output ctrlStrobe_t strobe,
  output logic        protOn,
  output logic        idMode
);
  localparam int CNT_W = $clog2(LOAD_WINDOW + 1);

  seqState_t        seqState, seqNext;
  logic [CNT_W-1:0] windowCnt;
  logic             windowOpen;
  logic             ordinary, reload;
  logic             setProt, clrProt, setId, clrId;

  // Behaves as a non-volatile bit: powers up protected, ignores rstN
  logic protFlag = 1'b1;

  assign windowOpen = (windowCnt != '0);
  assign protOn     = protFlag;

  always_comb begin
    seqNext           = seqState;
    ordinary          = 1'b0;
    reload            = 1'b0;
    setProt           = 1'b0;
    clrProt           = 1'b0;
    setId             = 1'b0;
    clrId             = 1'b0;
    strobe.passWrite  = 1'b0;
    strobe.openLoad   = 1'b0;
    strobe.startErase = 1'b0;
    strobe.idMode     = idMode;
    if (wrValid) begin
      if (windowOpen) begin
        strobe.passWrite = 1'b1;
        reload           = 1'b1;
      end else begin
        seqNext = SEQ_IDLE;
        unique case (seqState)
          SEQ_IDLE: if (hit.unlockA) seqNext = SEQ_C1; else ordinary = 1'b1;
          SEQ_C1:   if (hit.unlockB) seqNext = SEQ_C2; else ordinary = 1'b1;
          SEQ_C2: begin
            if (hit.atCmdAddr && hit.code == ENABLE_CODE) begin
              setProt         = 1'b1;
              strobe.openLoad = 1'b1;
              reload          = 1'b1;
            end else if (hit.atCmdAddr && hit.code == ID_EXIT_CODE) begin
              clrId = 1'b1;
            end else if (hit.atCmdAddr && hit.code == SIX_PREFIX) begin
              seqNext = SEQ_C3;
            end else begin
              ordinary = 1'b1;
            end
          end
          SEQ_C3:   if (hit.unlockA) seqNext = SEQ_C4; else ordinary = 1'b1;
          SEQ_C4:   if (hit.unlockB) seqNext = SEQ_C5; else ordinary = 1'b1;
          SEQ_C5: begin
            if (hit.atCmdAddr && hit.code == DISABLE_CODE)       clrProt = 1'b1;
            else if (hit.atCmdAddr && hit.code == ERASE_CODE)    strobe.startErase = 1'b1;
            else if (hit.atCmdAddr && hit.code == ID_ENTER_CODE) setId = 1'b1;
            else                                                 ordinary = 1'b1;
          end
          default: ordinary = 1'b1;
        endcase
        if (ordinary && !protFlag) begin
          strobe.passWrite = 1'b1;
          strobe.openLoad  = 1'b1;
          reload           = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (setProt)      protFlag <= 1'b1;
    else if (clrProt) protFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqState  <= SEQ_IDLE;
      windowCnt <= '0;
      idMode    <= 1'b0;
    end else begin
      seqState <= seqNext;
      if (reload)          windowCnt <= CNT_W'(LOAD_WINDOW);
      else if (windowOpen) windowCnt <= windowCnt - 1'b1;
      if (setId)      idMode <= 1'b1;
      else if (clrId) idMode <= 1'b0;
    end
  end

  AST_PROT_SET_BY_CMD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(protFlag) |-> $past(seqState) == SEQ_C2); // R2
  AST_PROT_CLR_BY_CMD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(protFlag) |-> $past(seqState) == SEQ_C5); // R5
  AST_ID_SET_BY_CMD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idMode) |-> $past(seqState) == SEQ_C5); // R10
  AST_SEQ_OUTSIDE_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    seqState != SEQ_IDLE |-> windowCnt == '0); // R4
endmodule

// File: rtl/wp_cmd_decoder.sv
module wp_cmd_decoder
  import wpdec_pkg::*;
#(
  parameter int         ADDR_W        = 17,
  parameter int         LOAD_WINDOW   = 6000,
  parameter logic [7:0] DISABLE_CODE  = 8'h20,
  parameter logic [7:0] ERASE_CODE    = 8'h10,
  parameter logic [7:0] ID_ENTER_CODE = 8'h60,
  parameter logic [7:0] ID_EXIT_CODE  = 8'hF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [7:0]        arrayRdData,
  output logic [7:0]        rdData,
  output logic              dataWrValid,
  output logic [ADDR_W-1:0] dataWrAddr,
  output logic [7:0]        dataWrData,
  output logic              loadStart,
  output logic              eraseStart,
  output logic              protOn,
  output logic              idMode
);
  localparam int CMD_BITS = 15;

  cmdHit_t     hit;
  ctrlStrobe_t strobe;

  wpdec_seq_ctrl #(
    .LOAD_WINDOW  (LOAD_WINDOW),
    .DISABLE_CODE (DISABLE_CODE),
    .ERASE_CODE   (ERASE_CODE),
    .ID_ENTER_CODE(ID_ENTER_CODE),
    .ID_EXIT_CODE (ID_EXIT_CODE)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .wrValid(wrValid),
    .hit    (hit),
    .strobe (strobe),
    .protOn (protOn),
    .idMode (idMode)
  );

  wpdec_datapath #(
    .ADDR_W  (ADDR_W),
    .CMD_BITS(CMD_BITS)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .wrValid    (wrValid),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .rdAddr     (rdAddr),
    .arrayRdData(arrayRdData),
    .strobe     (strobe),
    .hit        (hit),
    .rdData     (rdData),
    .dataWrValid(dataWrValid),
    .dataWrAddr (dataWrAddr),
    .dataWrData (dataWrData),
    .loadStart  (loadStart),
    .eraseStart (eraseStart)
  );
endmodule

// File: tb/wp_cmd_decoder_tb_top.sv
module wp_cmd_decoder_tb_top;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrValid = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [7:0]    wrData = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [7:0]    arrayRdData = 8'h5A;
  logic [7:0]    rdData;
  logic          dataWrValid;
  logic [AW-1:0] dataWrAddr;
  logic [7:0]    dataWrData;
  logic          loadStart, eraseStart, protOn, idMode;

  int  passCnt = 0;
  int  totalCnt = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  wp_cmd_decoder #(.ADDR_W(AW), .LOAD_WINDOW(6)) dut_i (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .arrayRdData(arrayRdData), .rdData(rdData),
    .dataWrValid(dataWrValid), .dataWrAddr(dataWrAddr), .dataWrData(dataWrData),
    .loadStart(loadStart), .eraseStart(eraseStart), .protOn(protOn), .idMode(idMode)
  );

  // expected flag order: {fwd, load, erase, prot, idm}
  typedef struct packed {
    logic [16:0] addr;
    logic [7:0]  data;
    logic [2:0]  gap;
    logic [4:0]  flags;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VECS [NV] = '{
    '{17'h01234, 8'h11, 3'd0, 5'b00010, 4'd3},  // R3 protected, dropped
    '{17'h05555, 8'hAA, 3'd0, 5'b00010, 4'd2},  // R2 arm
    '{17'h02AAA, 8'h55, 3'd0, 5'b00010, 4'd2},
    '{17'h05555, 8'hA0, 3'd0, 5'b01010, 4'd2},
    '{17'h00100, 8'h33, 3'd0, 5'b10010, 4'd4},  // R4 in window
    '{17'h00105, 8'h44, 3'd5, 5'b10010, 4'd4},  // R4 last in-window cycle
    '{17'h00106, 8'h55, 3'd6, 5'b00010, 4'd4},  // R4 window expired
    '{17'h05555, 8'hAA, 3'd0, 5'b00010, 4'd5},  // R5 disarm
    '{17'h02AAA, 8'h55, 3'd0, 5'b00010, 4'd5},
    '{17'h05555, 8'h80, 3'd0, 5'b00010, 4'd5},
    '{17'h05555, 8'hAA, 3'd0, 5'b00010, 4'd5},
    '{17'h02AAA, 8'h55, 3'd0, 5'b00010, 4'd5},
    '{17'h05555, 8'h20, 3'd0, 5'b00000, 4'd5},
    '{17'h02000, 8'h66, 3'd0, 5'b11000, 4'd6},  // R6 unprotected write
    '{17'h02001, 8'h67, 3'd0, 5'b10000, 4'd6},
    '{17'h15555, 8'hAA, 3'd6, 5'b00000, 4'd8},  // R8 high bits ignored
    '{17'h02AAA, 8'h55, 3'd0, 5'b00000, 4'd9},  // R9 erase
    '{17'h05555, 8'h80, 3'd0, 5'b00000, 4'd9},
    '{17'h05555, 8'hAA, 3'd0, 5'b00000, 4'd9},
    '{17'h02AAA, 8'h55, 3'd0, 5'b00000, 4'd9},
    '{17'h05555, 8'h10, 3'd0, 5'b00100, 4'd9},
    '{17'h05555, 8'hAA, 3'd0, 5'b00000, 4'd11}, // R11 abort
    '{17'h02AAA, 8'h55, 3'd0, 5'b00000, 4'd11},
    '{17'h05555, 8'h77, 3'd0, 5'b11000, 4'd11},
    '{17'h02AAA, 8'h55, 3'd6, 5'b11000, 4'd11},
    '{17'h05555, 8'hA0, 3'd0, 5'b10000, 4'd11},
    '{17'h05555, 8'hAA, 3'd6, 5'b00000, 4'd10}, // R10 id entry
    '{17'h02AAA, 8'h55, 3'd0, 5'b00000, 4'd10},
    '{17'h05555, 8'h80, 3'd0, 5'b00000, 4'd10},
    '{17'h05555, 8'hAA, 3'd0, 5'b00000, 4'd10},
    '{17'h02AAA, 8'h55, 3'd0, 5'b00000, 4'd10},
    '{17'h05555, 8'h60, 3'd0, 5'b00001, 4'd10}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    totalCnt++;
    if (ok) passCnt++;
    else $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
  endtask

  // starts on a negedge, returns on the negedge after the capturing edge
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wrAddr  = a;
    wrData  = d;
    wrValid = 1'b1;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  function automatic logic [4:0] flagsNow();
    return {dataWrValid, loadStart, eraseStart, protOn, idMode};
  endfunction

  task automatic pulseReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(flagsNow() == 5'b00010, "R1", "flags in reset", int'(flagsNow()), 2);
    rstN = 1'b1;
    @(negedge clk);
    check(flagsNow() == 5'b00010, "R1", "flags after reset", int'(flagsNow()), 2);

    for (int i = 0; i < NV; i++) begin
      repeat (VECS[i].gap) @(negedge clk);
      wr(VECS[i].addr, VECS[i].data);
      check(flagsNow() == VECS[i].flags, $sformatf("R%0d", VECS[i].req),
            $sformatf("vector %0d flags", i), int'(flagsNow()), int'(VECS[i].flags));
      if (VECS[i].flags[4])
        check(dataWrAddr == VECS[i].addr && dataWrData == VECS[i].data,
              $sformatf("R%0d", VECS[i].req), $sformatf("vector %0d addr/data", i),
              int'({dataWrAddr, dataWrData}), int'({VECS[i].addr, VECS[i].data}));
    end

    // R10 identifier reads
    rdAddr = 17'h00000; #1;
    check(rdData == 8'hDA, "R10", "id read addr 0", int'(rdData), 8'hDA);
    rdAddr = 17'h00001; #1;
    check(rdData == 8'hC1, "R10", "id read addr 1", int'(rdData), 8'hC1);
    rdAddr = 17'h00002; #1;
    check(rdData == 8'h5A, "R10", "id mode addr 2 array", int'(rdData), 8'h5A);
    @(negedge clk);
    wr(17'h05555, 8'hAA);
    wr(17'h02AAA, 8'h55);
    wr(17'h05555, 8'hF0);
    check(idMode == 1'b0, "R10", "id exit", int'(idMode), 0);
    rdAddr = 17'h00000; #1;
    check(rdData == 8'h5A, "R10", "addr 0 after exit", int'(rdData), 8'h5A);

    // R7 protection survives reset while clear
    @(negedge clk);
    pulseReset();
    check(protOn == 1'b0, "R7", "prot clear across reset", int'(protOn), 0);
    check(flagsNow() == 5'b00000, "R1", "flags after mid-run reset", int'(flagsNow()), 0);
    // re-arm, then reset again
    wr(17'h05555, 8'hAA);
    wr(17'h02AAA, 8'h55);
    wr(17'h05555, 8'hA0);
    check(protOn && loadStart, "R2", "re-arm", int'({protOn, loadStart}), 3);
    pulseReset();
    check(protOn == 1'b1, "R7", "prot set across reset", int'(protOn), 1);
    wr(17'h00300, 8'h99);
    check(dataWrValid == 1'b0, "R3", "dropped after reset", int'(dataWrValid), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      totalCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", passCnt, totalCnt);
      $finish;
    end
  end
endmodule